// File: doc/BRIEF.md
# Process Monitor Measurement Sequencer

This block is the digital controller in front of a bank of on-die oscillator test structures, such as plain and resistively loaded rings with their counters. A host asks for one measurement by raising a request together with a structure-select code. The sequencer powers up only the chosen structure and waits for that structure to report completion. It then captures that structure's 8-bit result word and presents it with a valid flag until the host acknowledges it. After the acknowledge it returns to idle, ready for the next request.

Every structure stays powered down unless a measurement is in progress, because a running oscillator draws significant current. The monitor is meant to be read at start-up and a few times afterwards, so one request and one readout at a time is enough. The structure count is a parameter. Adding a structure means widening the enable, done and result buses, and the sequencing stays the same. A select code with no structure behind it is answered with an error flag. A structure that never finishes is cut off by a timeout counted in the reference clock.

Top module: `pmon_seq`

## Requirements
- R1: While reset is asserted and just after it is released, all enable lines, busy, valid, err and tmo are low and result is 0.
- R2: A request accepted in idle with a select code below N_STRUCT drives exactly one enable line high, the bit whose index equals the code. That line rises at the clock edge after acceptance and stays high until completion or timeout. At no time is more than one enable line high.
- R3: All enable lines are low whenever no measurement is running: in idle, in the capture cycle and while a result is held for the host.
- R4: When the selected structure's done bit is sampled high, that structure's 8-bit word is taken from bits [8*i+7 : 8*i] of the result bus and appears on result at that same edge. Valid rises at the following edge.
- R5: Done bits and result words of structures that were not selected have no effect on the running measurement.
- R6: Valid, err, tmo and result hold steady until ack is sampled high. Ack then returns the block to idle, with busy, valid, err and tmo low.
- R7: If done has not arrived after TMO_CYC measuring cycles, all enables drop. The tmo flag rises, result reads 0 and valid stays low.
- R8: If the selected done arrives in the last measuring cycle before the deadline, the completion is taken: valid rises, tmo stays low and the word is captured.
- R9: A select code of N_STRUCT or above raises err at the next edge with result 0. No enable line rises, and valid stays low until ack.
- R10: A request, and the select code that comes with it, is ignored whenever busy is high, including while a result or flag waits for ack.
- R11: The highest structure index, N_STRUCT-1, is reachable and delivers its own slice of the result bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Measurement request, sampled in idle only |
| sel | input | SEL_W | Structure-select code |
| ack | input | 1 | Host acknowledge of the held result or flag |
| meas_done | input | N_STRUCT | Completion bit per structure |
| meas_res | input | N_STRUCT*RES_W | Packed result words, structure i at bits [RES_W*i +: RES_W] |
| en | output | N_STRUCT | One-hot power enable per structure |
| busy | output | 1 | High whenever the block is not idle |
| result | output | RES_W | Captured result word |
| valid | output | 1 | Result holds a completed measurement |
| err | output | 1 | Last request named an unimplemented structure |
| tmo | output | 1 | Last measurement hit the timeout |

## Verification
Completion and timeout can fall in the same cycle when the selected done bit arrives in the last measuring cycle before the deadline. The bench provokes this by timing the done bit from its own count of measuring cycles. It expects valid with the captured word and no tmo flag. The second collision is a request during a busy phase, including the cycle-exact overlap with the held result. The bench judges that case by whether the enable pattern and the held outputs stay unchanged. Both cases are also compared on every clock against a behavioural model in the bench.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS,
    ST_LATCH,
    ST_READY
  } pmon_state_e;

  // A select code is legal when a structure sits behind it.
  function automatic logic code_legal(input int unsigned code, input int unsigned count);
    return code < count;
  endfunction

  // Low bit of a structure's slice in the packed result bus.
  function automatic int unsigned slice_base(input int unsigned idx, input int unsigned width);
    return idx * width;
  endfunction

endpackage

// File: rtl/pmon_en_dec.sv
module pmon_en_dec #(
  parameter int N_STRUCT = 3,
  parameter int SEL_W    = 2
) (
  input  logic                on,
  input  logic [SEL_W-1:0]    code,
  output logic [N_STRUCT-1:0] en
);

  for (genvar i = 0; i < N_STRUCT; i++) begin : g_line
    assign en[i] = on && (code == SEL_W'(i));
  end

endmodule

// File: rtl/pmon_res_mux.sv
module pmon_res_mux #(
  parameter int N_STRUCT = 3,
  parameter int SEL_W    = 2,
  parameter int RES_W    = 8
) (
  input  logic [SEL_W-1:0]          code,
  input  logic [N_STRUCT-1:0]       done_bus,
  input  logic [N_STRUCT*RES_W-1:0] res_bus,
  output logic                      done_sel,
  output logic [RES_W-1:0]          word_sel
);
  import pmon_pkg::*;

  always_comb begin
    done_sel = 1'b0;
    word_sel = '0;
    for (int i = 0; i < N_STRUCT; i++) begin
      if (code == SEL_W'(i)) begin
        done_sel = done_bus[i];
        word_sel = res_bus[slice_base(i, RES_W) +: RES_W];
      end
    end
  end

endmodule

// File: rtl/pmon_tmo.sv
module pmon_tmo #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!expire) cnt <= cnt + CW'(1);
  end

  // R7: the count never passes the deadline while measuring
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(LIMIT)));

endmodule

// File: rtl/pmon_seq.sv
module pmon_seq #(
  parameter int N_STRUCT = 3,
  parameter int SEL_W    = 2,
  parameter int RES_W    = 8,
  parameter int TMO_CYC  = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      ack,
  input  logic [N_STRUCT-1:0]       meas_done,
  input  logic [N_STRUCT*RES_W-1:0] meas_res,
  output logic [N_STRUCT-1:0]       en,
  output logic                      busy,
  output logic [RES_W-1:0]          result,
  output logic                      valid,
  output logic                      err,
  output logic                      tmo
);
  import pmon_pkg::*;

  pmon_state_e      state;
  logic [SEL_W-1:0] sel_q;
  logic [RES_W-1:0] result_q;
  logic             err_q, tmo_q;

  // named events for the assertions
  logic run_en, done_sel, expire;
  logic accept_ev, accept_ok, accept_bad, done_ev, tmo_ev, ack_ev;
  logic [RES_W-1:0] word_sel;

  assign run_en     = (state == ST_ARM) || (state == ST_MEAS);
  assign accept_ev  = (state == ST_IDLE) && req;
  assign accept_ok  = accept_ev && code_legal(32'(sel), N_STRUCT);
  assign accept_bad = accept_ev && !accept_ok;
  assign done_ev    = (state == ST_MEAS) && done_sel;
  assign tmo_ev     = (state == ST_MEAS) && expire && !done_sel;
  assign ack_ev     = (state == ST_READY) && ack;

  pmon_en_dec #(.N_STRUCT(N_STRUCT), .SEL_W(SEL_W)) u_dec (
    .on(run_en), .code(sel_q), .en(en)
  );

  pmon_res_mux #(.N_STRUCT(N_STRUCT), .SEL_W(SEL_W), .RES_W(RES_W)) u_mux (
    .code(sel_q), .done_bus(meas_done), .res_bus(meas_res),
    .done_sel(done_sel), .word_sel(word_sel)
  );

  pmon_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(state == ST_MEAS), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel_q    <= '0;
      result_q <= '0;
      err_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept_ok) begin
            sel_q <= sel;
            state <= ST_ARM;
          end else if (accept_bad) begin
            err_q    <= 1'b1;
            result_q <= '0;
            state    <= ST_READY;
          end
        end
        ST_ARM:  state <= ST_MEAS;
        ST_MEAS: begin
          if (done_ev) begin
            result_q <= word_sel;
            state    <= ST_LATCH;
          end else if (tmo_ev) begin
            result_q <= '0;
            tmo_q    <= 1'b1;
            state    <= ST_READY;
          end
        end
        ST_LATCH: state <= ST_READY;
        ST_READY: begin
          if (ack_ev) begin
            err_q <= 1'b0;
            tmo_q <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign result = result_q;
  assign err    = err_q;
  assign tmo    = tmo_q;
  assign valid  = (state == ST_READY) && !err_q && !tmo_q;

  assert_onehot_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en));

  assert_arm_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ok |=> ($countones(en) == 1));

  assert_dark_when_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || valid || err || tmo) |-> (en == '0));

  assert_valid_follows_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (!valid && !tmo) ##1 valid);

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> (valid && $stable(result)));

  assert_tmo_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> ((en == '0) && !valid));

  assert_done_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && expire) |=> !tmo);

  assert_err_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ((en == '0) && !valid));

  assert_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_q));

endmodule

// File: tb/tb_pmon_seq.sv
module tb_pmon_seq;
  localparam int NS   = 3;
  localparam int SW   = 2;
  localparam int RW   = 8;
  localparam int TMOT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [SW-1:0] sel = '0;
  logic ack = 1'b0;
  logic [NS-1:0] sdone = '0;
  logic [RW-1:0] sres [NS];
  logic [NS*RW-1:0] res_bus;
  logic [NS-1:0] en;
  logic busy, valid, err, tmo;
  logic [RW-1:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  assign res_bus = {sres[2], sres[1], sres[0]};

  pmon_seq #(.N_STRUCT(NS), .SEL_W(SW), .RES_W(RW), .TMO_CYC(TMOT)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .sel(sel), .ack(ack),
    .meas_done(sdone), .meas_res(res_bus), .en(en), .busy(busy),
    .result(result), .valid(valid), .err(err), .tmo(tmo)
  );

  // behavioural reference: 0 idle, 1 powering, 2 counting, 3 capture, 4 holding
  int m_st, m_sel, m_cnt, m_res;
  bit m_err, m_tmo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_sel <= 0; m_cnt <= 0; m_res <= 0; m_err <= 0; m_tmo <= 0;
    end else if (m_st == 0) begin
      if (req && int'(sel) < NS) begin m_sel <= int'(sel); m_st <= 1; end
      else if (req) begin m_err <= 1; m_res <= 0; m_st <= 4; end
    end else if (m_st == 1) begin
      m_st <= 2; m_cnt <= 0;
    end else if (m_st == 2) begin
      if (sdone[m_sel]) begin m_res <= int'(sres[m_sel]); m_st <= 3; end
      else if (m_cnt == TMOT - 1) begin m_tmo <= 1; m_res <= 0; m_st <= 4; end
      else m_cnt <= m_cnt + 1;
    end else if (m_st == 3) begin
      m_st <= 4;
    end else if (ack) begin
      m_st <= 0; m_err <= 0; m_tmo <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2/R3 en", int'(en), (m_st == 1 || m_st == 2) ? (1 << m_sel) : 0);
      chk("R10 busy", int'(busy), int'(m_st != 0));
      chk("R6 valid", int'(valid), int'(m_st == 4 && !m_err && !m_tmo));
      chk("R9 err", int'(err), int'(m_err));
      chk("R7 tmo", int'(tmo), int'(m_tmo));
      chk("R4 result", int'(result), m_res);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input int code);
    req = 1'b1; sel = SW'(code);
    tick(1);
    req = 1'b0; sel = '0;
  endtask

  task automatic release_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) sres[i] = '0;
    tick(3);
    chk("R1 reset en", int'(en), 0);
    chk("R1 reset flags", int'({busy, valid, err, tmo}), 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 after release", int'({busy, valid, err, tmo, en}), 0);
    chk("R1 result", int'(result), 0);
    cmp_on = 1'b1;

    // R2/R4: structure 0, done after a few cycles
    sres[0] = 8'hA5;
    request(0);
    chk("R2 enable bit 0", int'(en), 1);
    tick(4);
    sdone[0] = 1'b1;
    tick(1);
    sdone[0] = 1'b0;
    chk("R4 word at done edge", int'(result), 'hA5);
    chk("R4 valid not yet", int'(valid), 0);
    chk("R3 dark in capture", int'(en), 0);
    tick(1);
    chk("R4 valid one edge later", int'(valid), 1);
    sres[0] = 8'h00;
    tick(3);
    chk("R6 valid held", int'(valid), 1);
    chk("R6 result held", int'(result), 'hA5);
    release_ack();
    chk("R6 idle after ack", int'({busy, valid}), 0);

    // R5: foreign done bits ignored
    sres[1] = 8'h3C; sres[0] = 8'h11; sres[2] = 8'h22;
    request(1);
    tick(1);
    sdone = 3'b101;
    tick(3);
    chk("R5 still measuring", int'(en), 2);
    chk("R5 no valid", int'(valid), 0);
    sdone = 3'b010;
    tick(1);
    sdone = '0;
    tick(1);
    chk("R5 own word", int'(result), 'h3C);

    // R10: request during hold ignored
    request(2);
    chk("R10 still holding", int'(valid), 1);
    chk("R10 no enable", int'(en), 0);
    release_ack();

    // R10 during measurement, R11 top index
    sres[2] = 8'h5A;
    request(2);
    tick(2);
    request(0);
    chk("R10 enable unchanged", int'(en), 4);
    sdone[2] = 1'b1; tick(1); sdone[2] = 1'b0;
    tick(1);
    chk("R11 top slice", int'(result), 'h5A);
    release_ack();

    // R9: unimplemented code
    request(3);
    chk("R9 err raised", int'(err), 1);
    chk("R9 no enable", int'(en), 0);
    chk("R9 result zero", int'(result), 0);
    tick(3);
    chk("R9 err held", int'(err), 1);
    release_ack();
    chk("R9 cleared by ack", int'(err), 0);

    // R7: timeout
    request(0);
    tick(TMOT + 2);
    chk("R7 tmo flag", int'(tmo), 1);
    chk("R7 enables dropped", int'(en), 0);
    chk("R7 no valid", int'(valid), 0);
    release_ack();

    // R8: done in the deadline cycle
    sres[2] = 8'h7E;
    request(2);
    while (!(m_st == 2 && m_cnt == TMOT - 1)) tick(1);
    sdone[2] = 1'b1; tick(1); sdone[2] = 1'b0;
    tick(1);
    chk("R8 valid wins", int'(valid), 1);
    chk("R8 no tmo", int'(tmo), 0);
    chk("R8 word", int'(result), 'h7E);
    release_ack();

    // R2 re-arm after everything
    request(1);
    chk("R2 re-armed", int'(en), 2);
    tick(2);

    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule